// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This block moves data between I/O devices and memory without the processor doing each move. Software programs each of four channels through a small register port. It sets a start address, a transfer count and a mode word, and clears the channel's mask bit. A device then raises its request line, or software sets the channel's request bit. The engine asks the processor for the bus with a hold request and waits for the grant. It then runs transfer cycles. In each cycle it puts the channel address on the address bus, asserts the channel acknowledge, and pulses one memory strobe and one I/O strobe. Finally it releases the bus.

Three transfer types control how long a channel keeps the bus. Single does one move per grant. Block runs until the count is used up or the end-of-process input fires. Demand behaves like block, and also yields when the device withdraws its request. When a channel terminates, the engine does one of two things. With auto-initialization on, it reloads the channel from its saved base values. Otherwise it masks the channel. In both cases it sets the channel's terminal-count status flag. The data path itself is outside the block: each transfer is modelled only by its strobes and address.

Top module: `dmaEngine`

## Requirements
- R1: Register port addresses: bit 4 clear selects a channel register, with the channel number in bits 3:2 and the register in bits 1:0. Register 0 is the address, 1 is the count and 2 is the mode. Writing the address or the count loads both the base copy and the current register. Reading registers 0 and 1 returns the current values.
- R2: A channel with count N performs N+1 transfers. The count decrements once per transfer, and terminal count is the transfer made while the count is 0000h; after it the current count reads FFFFh. `done` is high during the terminating transfer cycle only.
- R3: Mode bit 1 selects the address step. With bit 1 clear the current address rises by one after every transfer; with bit 1 set it falls by one.
- R4: Mode bit 0 selects the direction. With bit 0 clear each transfer pulses `ioRd` and `memWr`; with bit 0 set it pulses `memRd` and `ioWr`.
- R5: No acknowledge or strobe appears until `holdAck` is high while `holdReq` is high. `holdReq` drops when a service ends. A new service waits until `holdAck` has gone low.
- R6: Mode bits 4:3 set the transfer type: 0 is single, 1 is block, 2 is demand, 3 behaves as single. In single mode each grant carries exactly one transfer and is then released.
- R7: In block mode transfers continue back to back in one grant until terminal count, or until `eopIn` is high during a transfer cycle. That transfer is the last one, and termination by `eopIn` has the same effects as terminal count.
- R8: In demand mode the service also ends after the transfer during which the channel's device request is low. The channel's count and address keep their progress, and the mask bit stays clear.
- R9: Register 10h holds the mask bits, one per channel in bits 3:0, and resets to Fh. A set bit keeps the channel from being serviced. Register 11h holds software request bits, which start a service like a device request; a channel's bit clears when its service ends.
- R10: When several unmasked channels request at once, the lowest-numbered channel is serviced first.
- R11: Mode bit 2 enables auto-initialization. On termination with it set, the current address and count reload from their base copies and the mask bit stays clear. With it clear, the channel's mask bit is set.
- R12: Register 12h returns a terminal-count flag for each channel in bits 3:0. A flag is set on termination, and a read of 12h clears the flags.
- R13: At most one acknowledge line is high at any time. The acknowledge is high for the whole transfer cycle. Outside transfer cycles every strobe is low and the address bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWe | input | 1 | Register write enable |
| hostRe | input | 1 | Register read enable (clears status on address 12h) |
| hostAddr | input | 5 | Register address |
| hostWdata | input | 16 | Register write data |
| hostRdata | output | 16 | Register read data (combinational) |
| devReq | input | 4 | Per-channel device request |
| devAck | output | 4 | Per-channel acknowledge |
| eopIn | input | 1 | External end-of-process |
| holdReq | output | 1 | Bus hold request to the processor |
| holdAck | input | 1 | Bus hold grant from the processor |
| busAddr | output | 16 | Transfer address |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | I/O read strobe |
| ioWr | output | 1 | I/O write strobe |
| done | output | 1 | Termination indication |

## Verification
The tests drive the engine with held device requests, software requests, a request withdrawn part-way through a demand service, and an end-of-process pulse during a long block. Each pattern separates the three transfer types by the number of transfers per grant and the number of bus releases. Increasing and decreasing runs in opposite directions show the address step and the strobe pairing. Simultaneous requests show the priority order. A grant withheld by the processor shows that the engine waits for it. Reading back the registers after each service shows the difference between auto-reload and self-masking, and that the status flags clear on read.

// File: rtl/dmaPkg.sv
package dmaPkg;
  parameter int NUM_CH  = 4;
  parameter int ADDR_W  = 16;
  parameter int CNT_W   = 16;
  parameter int HADDR_W = 5;
  parameter int HDATA_W = 16;
  localparam int CH_W   = $clog2(NUM_CH);

  typedef enum logic [1:0] {
    XT_SINGLE = 2'd0,
    XT_BLOCK  = 2'd1,
    XT_DEMAND = 2'd2,
    XT_RSVD   = 2'd3
  } xferType_e;

  typedef struct packed {
    xferType_e xType;
    logic      autoInit;
    logic      addrDec;
    logic      memToIo;
  } chanMode_t;

  typedef struct packed {
    logic            step;
    logic            finish;
    logic            endSvc;
    logic [CH_W-1:0] chan;
  } ctlStrobe_t;
endpackage

// File: rtl/dmaChanFile.sv
module dmaChanFile
  import dmaPkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int AW  = ADDR_W,
  parameter int CW  = CNT_W,
  parameter int HAW = HADDR_W,
  parameter int HDW = HDATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostWe,
  input  logic                   hostRe,
  input  logic [HAW-1:0]         hostAddr,
  input  logic [HDW-1:0]         hostWdata,
  output logic [HDW-1:0]         hostRdata,
  input  logic [NCH-1:0]         devReq,
  input  ctlStrobe_t             ctl,
  output logic [NCH-1:0][AW-1:0] curAddrVec,
  output logic [NCH-1:0]         cntZero,
  output xferType_e [NCH-1:0]    typeVec,
  output logic [NCH-1:0]         dirVec,
  output logic [NCH-1:0]         reqLive,
  output logic [NCH-1:0]         reqEligible
);
  localparam int CHW = $clog2(NCH);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [1:0] SUB_ADDR = 2'd0, SUB_CNT = 2'd1, SUB_MODE = 2'd2;
  localparam logic [1:0] G_MASK = 2'd0, G_SWREQ = 2'd1, G_STAT = 2'd2;

  logic [NCH-1:0][CW-1:0] curCntVec;
  chanMode_t [NCH-1:0]    modeVec;
  logic [NCH-1:0]         maskR, swReqR, tcFlagR;

  logic          isGlobal;
  logic [CHW-1:0] selCh;
  logic [1:0]    subSel;
  assign isGlobal = hostAddr[HAW-1];
  assign selCh    = hostAddr[CHW+1:2];
  assign subSel   = hostAddr[1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [AW-1:0] baseAddr, curAddr;
    logic [CW-1:0] baseCnt, curCnt;
    chanMode_t     modeR;
    logic          chWr, mine;

    assign chWr = hostWe && !isGlobal && (selCh == CHW'(i));
    assign mine = ctl.step && (ctl.chan == CHW'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseAddr <= '0;
        curAddr  <= '0;
        baseCnt  <= '0;
        curCnt   <= '0;
        modeR    <= '0;
      end else begin
        if (mine) begin
          if (ctl.finish && modeR.autoInit) begin
            curAddr <= baseAddr;
            curCnt  <= baseCnt;
          end else begin
            curAddr <= modeR.addrDec ? curAddr - ADDR_ONE : curAddr + ADDR_ONE;
            curCnt  <= curCnt - CNT_ONE;
          end
        end
        if (chWr && subSel == SUB_ADDR) begin
          baseAddr <= hostWdata[AW-1:0];
          curAddr  <= hostWdata[AW-1:0];
        end
        if (chWr && subSel == SUB_CNT) begin
          baseCnt <= hostWdata[CW-1:0];
          curCnt  <= hostWdata[CW-1:0];
        end
        if (chWr && subSel == SUB_MODE) modeR <= chanMode_t'(hostWdata[$bits(chanMode_t)-1:0]);
      end
    end

    assign curAddrVec[i] = curAddr;
    assign curCntVec[i]  = curCnt;
    assign modeVec[i]    = modeR;
    assign cntZero[i]    = (curCnt == '0);
    assign typeVec[i]    = modeR.xType;
    assign dirVec[i]     = modeR.memToIo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskR   <= '1;
      swReqR  <= '0;
      tcFlagR <= '0;
    end else begin
      if (hostWe && isGlobal && subSel == G_MASK)  maskR  <= hostWdata[NCH-1:0];
      if (hostWe && isGlobal && subSel == G_SWREQ) swReqR <= hostWdata[NCH-1:0];
      if (hostRe && isGlobal && subSel == G_STAT)  tcFlagR <= '0;
      for (int i = 0; i < NCH; i++) begin
        if (ctl.finish && ctl.chan == CHW'(i)) begin
          tcFlagR[i] <= 1'b1;
          if (!modeVec[i].autoInit) maskR[i] <= 1'b1;
        end
        if (ctl.endSvc && ctl.chan == CHW'(i)) swReqR[i] <= 1'b0;
      end
    end
  end

  assign reqLive     = devReq | swReqR;
  assign reqEligible = reqLive & ~maskR;

  always_comb begin
    hostRdata = '0;
    if (isGlobal) begin
      case (subSel)
        G_MASK:  hostRdata = HDW'(maskR);
        G_SWREQ: hostRdata = HDW'(swReqR);
        G_STAT:  hostRdata = HDW'(tcFlagR);
        default: hostRdata = '0;
      endcase
    end else begin
      case (subSel)
        SUB_ADDR: hostRdata = HDW'(curAddrVec[selCh]);
        SUB_CNT:  hostRdata = HDW'(curCntVec[selCh]);
        SUB_MODE: hostRdata = HDW'(modeVec[selCh]);
        default:  hostRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmaSeq.sv
module dmaSeq
  import dmaPkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int AW  = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   holdAck,
  input  logic                   eopIn,
  input  logic [NCH-1:0]         reqEligible,
  input  logic [NCH-1:0]         reqLive,
  input  logic [NCH-1:0]         cntZero,
  input  xferType_e [NCH-1:0]    typeVec,
  input  logic [NCH-1:0]         dirVec,
  input  logic [NCH-1:0][AW-1:0] curAddrVec,
  output ctlStrobe_t             ctl,
  output logic                   holdReq,
  output logic [NCH-1:0]         devAck,
  output logic [AW-1:0]          busAddr,
  output logic                   memRd,
  output logic                   memWr,
  output logic                   ioRd,
  output logic                   ioWr,
  output logic                   done
);
  localparam int CHW = $clog2(NCH);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_XFER, S_REL} seqState_e;
  seqState_e state;
  logic [CHW-1:0] actCh, pickCh;
  logic found, inXfer, termNow, stopNow;
  xferType_e actType;

  always_comb begin
    pickCh = '0;
    found  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (reqEligible[i]) begin
        pickCh = CHW'(i);
        found  = 1'b1;
      end
    end
  end

  assign inXfer  = (state == S_XFER);
  assign actType = typeVec[actCh];
  assign termNow = inXfer && (cntZero[actCh] || eopIn);
  always_comb begin
    case (actType)
      XT_BLOCK:  stopNow = termNow;
      XT_DEMAND: stopNow = termNow || !reqLive[actCh];
      default:   stopNow = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      actCh <= '0;
    end else begin
      case (state)
        S_IDLE: if (found) begin
          state <= S_HOLD;
          actCh <= pickCh;
        end
        S_HOLD: if (holdAck) state <= S_XFER;
        S_XFER: if (stopNow) state <= S_REL;
        S_REL:  if (!holdAck) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ctl.step   = inXfer;
  assign ctl.finish = termNow;
  assign ctl.endSvc = inXfer && stopNow;
  assign ctl.chan   = actCh;

  assign holdReq = (state == S_HOLD) || inXfer;
  always_comb begin
    devAck = '0;
    if (inXfer) devAck[actCh] = 1'b1;
  end
  assign busAddr = inXfer ? curAddrVec[actCh] : '0;
  assign memRd   = inXfer &&  dirVec[actCh];
  assign ioWr    = inXfer &&  dirVec[actCh];
  assign memWr   = inXfer && !dirVec[actCh];
  assign ioRd    = inXfer && !dirVec[actCh];
  assign done    = termNow;
endmodule

// File: rtl/dmaEngine.sv
module dmaEngine
  import dmaPkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int AW  = ADDR_W,
  parameter int CW  = CNT_W,
  parameter int HAW = HADDR_W,
  parameter int HDW = HDATA_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hostWe,
  input  logic           hostRe,
  input  logic [HAW-1:0] hostAddr,
  input  logic [HDW-1:0] hostWdata,
  output logic [HDW-1:0] hostRdata,
  input  logic [NCH-1:0] devReq,
  output logic [NCH-1:0] devAck,
  input  logic           eopIn,
  output logic           holdReq,
  input  logic           holdAck,
  output logic [AW-1:0]  busAddr,
  output logic           memRd,
  output logic           memWr,
  output logic           ioRd,
  output logic           ioWr,
  output logic           done
);
  ctlStrobe_t             ctl;
  logic [NCH-1:0][AW-1:0] curAddrVec;
  logic [NCH-1:0]         cntZero, dirVec, reqLive, reqEligible;
  xferType_e [NCH-1:0]    typeVec;

  dmaChanFile #(.NCH(NCH), .AW(AW), .CW(CW), .HAW(HAW), .HDW(HDW)) u_regs (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .devReq(devReq), .ctl(ctl), .curAddrVec(curAddrVec), .cntZero(cntZero),
    .typeVec(typeVec), .dirVec(dirVec), .reqLive(reqLive), .reqEligible(reqEligible)
  );

  dmaSeq #(.NCH(NCH), .AW(AW)) u_seq (
    .clk(clk), .rstN(rstN), .holdAck(holdAck), .eopIn(eopIn),
    .reqEligible(reqEligible), .reqLive(reqLive), .cntZero(cntZero),
    .typeVec(typeVec), .dirVec(dirVec), .curAddrVec(curAddrVec), .ctl(ctl),
    .holdReq(holdReq), .devAck(devAck), .busAddr(busAddr),
    .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr), .done(done)
  );
endmodule

// File: rtl/dmaEngineChk.sv
module dmaEngineChk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic [NCH-1:0] devAck,
  input logic           holdReq,
  input logic           holdAck,
  input logic [AW-1:0]  busAddr,
  input logic           memRd,
  input logic           memWr,
  input logic           ioRd,
  input logic           ioWr,
  input logic           done
);
  p_ack_needs_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|devAck) |-> (holdReq && holdAck));

  p_ack_onehot_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devAck));

  p_strobe_pairing_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|devAck) |-> ((memRd ^ memWr) && (ioRd ^ ioWr) && (memRd == ioWr)));

  p_quiet_bus_r13: assert property (@(posedge clk) disable iff (!rstN)
    !(|devAck) |-> (!memRd && !memWr && !ioRd && !ioWr && busAddr == '0));

  p_done_in_xfer_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (|devAck));

  p_release_after_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!(|devAck) && !holdReq));
endmodule

bind dmaEngine dmaEngineChk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .devAck(devAck), .holdReq(holdReq), .holdAck(holdAck),
  .busAddr(busAddr), .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr), .done(done)
);

// File: tb/sim_dmaEngine.sv
`timescale 1ns/1ps
module sim_dmaEngine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0, hostRe = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic [3:0]  devReq = '0;
  logic [3:0]  devAck;
  logic        eopIn = 1'b0;
  logic        holdReq, holdAck = 1'b0;
  logic [15:0] busAddr;
  logic        memRd, memWr, ioRd, ioWr, done;
  logic        stall = 1'b0;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  localparam logic [4:0] A_MASK = 5'h10, A_SWREQ = 5'h11, A_STAT = 5'h12;

  always #4 clk = ~clk;

  dmaEngine u0 (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .devReq(devReq), .devAck(devAck),
    .eopIn(eopIn), .holdReq(holdReq), .holdAck(holdAck), .busAddr(busAddr),
    .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr), .done(done)
  );

  // processor model: grants one cycle after the request unless stalled
  always @(posedge clk) holdAck <= holdReq && !stall;

  // bus monitor
  int xfers, doneCnt, holdFalls, holdRises, memRdCnt, memWrCnt, ioRdCnt, ioWrCnt, firstCh;
  logic [15:0] firstAddr, lastAddr;
  logic lastDone, holdPrev;
  always @(negedge clk) begin
    if (rstN) begin
      if (holdPrev && !holdReq) holdFalls++;
      if (!holdPrev && holdReq) holdRises++;
      holdPrev = holdReq;
      if (|devAck) begin
        if (xfers == 0) begin
          firstAddr = busAddr;
          for (int k = 0; k < 4; k++) if (devAck[k]) firstCh = k;
        end
        lastAddr = busAddr;
        lastDone = done;
        xfers++;
        memRdCnt += int'(memRd); memWrCnt += int'(memWr);
        ioRdCnt  += int'(ioRd);  ioWrCnt  += int'(ioWr);
      end
      if (done) doneCnt++;
    end else holdPrev = 1'b0;
  end

  task automatic clearMon();
    @(posedge clk);
    xfers = 0; doneCnt = 0; holdFalls = 0; holdRises = 0; firstCh = -1;
    memRdCnt = 0; memWrCnt = 0; ioRdCnt = 0; ioWrCnt = 0; lastDone = 0;
    firstAddr = '0; lastAddr = '0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostRe = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRe = 1'b0;
  endtask

  function automatic logic [4:0] chReg(input int ch, input int sub);
    return {1'b0, 2'(ch), 2'(sub)};
  endfunction

  task automatic progChan(input int ch, input logic [15:0] a, input logic [15:0] c,
                          input logic [15:0] m);
    hostWrite(chReg(ch, 0), a);
    hostWrite(chReg(ch, 1), c);
    hostWrite(chReg(ch, 2), m);
  endtask

  task automatic waitIdle();
    int quiet = 0;
    for (int n = 0; n < 2000 && quiet < 6; n++) begin
      @(negedge clk);
      if (!holdReq && !holdAck) quiet++; else quiet = 0;
    end
  endtask

  task automatic testReset();
    logic [15:0] d;
    #1;
    check(holdReq == 1'b0 && devAck == 4'h0, "R13 reset bus idle", {devAck, 3'b0, holdReq}, 0);
    hostRead(A_MASK, d);
    check(d == 16'h000F, "R9 reset mask", d, 16'h000F);
    hostRead(A_STAT, d);
    check(d == 16'h0000, "R12 reset status", d, 0);
  endtask

  task automatic testBlockInc();
    logic [15:0] d;
    progChan(0, 16'h1000, 16'd3, 16'h0008);
    hostRead(chReg(0, 0), d);
    check(d == 16'h1000, "R1 address readback", d, 16'h1000);
    hostRead(chReg(0, 1), d);
    check(d == 16'd3, "R1 count readback", d, 3);
    clearMon();
    hostWrite(A_MASK, 16'h000E);
    devReq[0] = 1'b1;
    waitIdle();
    devReq[0] = 1'b0;
    check(xfers == 4, "R2 count+1 transfers", xfers, 4);
    check(holdRises == 1, "R7 block single grant", holdRises, 1);
    check(firstAddr == 16'h1000 && lastAddr == 16'h1003, "R3 increment", lastAddr, 16'h1003);
    check(ioRdCnt == 4 && memWrCnt == 4 && memRdCnt == 0 && ioWrCnt == 0,
          "R4 write direction", memRdCnt + ioWrCnt, 0);
    check(doneCnt == 1 && lastDone, "R2 done on last", doneCnt, 1);
    hostRead(chReg(0, 1), d);
    check(d == 16'hFFFF, "R2 count wraps", d, 16'hFFFF);
    hostRead(chReg(0, 0), d);
    check(d == 16'h1004, "R3 final address", d, 16'h1004);
    hostRead(A_MASK, d);
    check(d[0] == 1'b1, "R11 self-mask", d, 16'h000F);
    hostRead(A_STAT, d);
    check(d == 16'h0001, "R12 flag set", d, 1);
    hostRead(A_STAT, d);
    check(d == 16'h0000, "R12 read clears", d, 0);
  endtask

  task automatic testBlockDecSw();
    logic [15:0] d;
    progChan(1, 16'h2000, 16'd2, 16'h000B);
    clearMon();
    hostWrite(A_MASK, 16'h000D);
    hostWrite(A_SWREQ, 16'h0002);
    waitIdle();
    check(xfers == 3, "R9 software request", xfers, 3);
    check(firstAddr == 16'h2000 && lastAddr == 16'h1FFE, "R3 decrement", lastAddr, 16'h1FFE);
    check(memRdCnt == 3 && ioWrCnt == 3 && ioRdCnt == 0 && memWrCnt == 0,
          "R4 read direction", ioRdCnt + memWrCnt, 0);
    hostRead(A_SWREQ, d);
    check(d == 16'h0000, "R9 sw bit clears", d, 0);
    hostRead(A_STAT, d);
  endtask

  task automatic testSingle();
    logic [15:0] d;
    progChan(2, 16'h4000, 16'd2, 16'h0000);
    clearMon();
    hostWrite(A_MASK, 16'h000B);
    devReq[2] = 1'b1;
    waitIdle();
    devReq[2] = 1'b0;
    check(xfers == 3, "R6 single transfers", xfers, 3);
    check(holdFalls == 3, "R6 release per transfer", holdFalls, 3);
    check(lastAddr == 16'h4002, "R6 single address", lastAddr, 16'h4002);
    hostRead(A_STAT, d);
    check(d == 16'h0004, "R12 flag channel 2", d, 4);
  endtask

  task automatic testDemand();
    logic [15:0] d;
    int seen = 0;
    progChan(3, 16'h5000, 16'd9, 16'h0010);
    clearMon();
    hostWrite(A_MASK, 16'h0007);
    devReq[3] = 1'b1;
    for (int n = 0; n < 200 && seen < 3; n++) begin
      @(negedge clk);
      if (devAck[3]) begin
        seen++;
        if (seen == 3) devReq[3] = 1'b0;
      end
    end
    waitIdle();
    check(xfers == 3, "R8 demand stops on drop", xfers, 3);
    hostRead(chReg(3, 1), d);
    check(d == 16'd6, "R8 count kept", d, 6);
    hostRead(chReg(3, 0), d);
    check(d == 16'h5003, "R8 address kept", d, 16'h5003);
    hostRead(A_MASK, d);
    check(d[3] == 1'b0, "R8 mask stays clear", d, 16'h0007);
    hostRead(A_STAT, d);
    check(d == 16'h0000, "R12 no flag on drop", d, 0);
    hostWrite(A_MASK, 16'h000F);
  endtask

  task automatic testEop();
    logic [15:0] d;
    int seen = 0;
    progChan(0, 16'h6000, 16'd20, 16'h0008);
    clearMon();
    hostWrite(A_MASK, 16'h000E);
    devReq[0] = 1'b1;
    for (int n = 0; n < 200 && seen < 2; n++) begin
      @(negedge clk);
      if (devAck[0]) begin
        seen++;
        if (seen == 2) eopIn = 1'b1;
      end
    end
    @(negedge clk);
    eopIn = 1'b0;
    waitIdle();
    devReq[0] = 1'b0;
    check(xfers == 2, "R7 end-of-process", xfers, 2);
    check(doneCnt == 1, "R7 done on eop", doneCnt, 1);
    hostRead(chReg(0, 1), d);
    check(d == 16'd18, "R7 count after eop", d, 18);
    hostRead(A_STAT, d);
    check(d == 16'h0001, "R12 flag on eop", d, 1);
  endtask

  task automatic testAutoInit();
    logic [15:0] d;
    progChan(1, 16'h3000, 16'd1, 16'h000C);
    clearMon();
    hostWrite(A_MASK, 16'h000D);
    hostWrite(A_SWREQ, 16'h0002);
    waitIdle();
    check(xfers == 2 && lastAddr == 16'h3001, "R11 autoinit run", xfers, 2);
    hostRead(chReg(1, 0), d);
    check(d == 16'h3000, "R11 address reloaded", d, 16'h3000);
    hostRead(chReg(1, 1), d);
    check(d == 16'd1, "R11 count reloaded", d, 1);
    hostRead(A_MASK, d);
    check(d == 16'h000D, "R11 stays enabled", d, 16'h000D);
    hostRead(A_STAT, d);
    check(d == 16'h0002, "R12 flag channel 1", d, 2);
    hostWrite(A_MASK, 16'h000F);
  endtask

  task automatic testPriority();
    logic [15:0] d;
    progChan(1, 16'h7100, 16'd0, 16'h0000);
    progChan(2, 16'h7200, 16'd0, 16'h0000);
    clearMon();
    hostWrite(A_MASK, 16'h0009);
    @(negedge clk);
    devReq[1] = 1'b1; devReq[2] = 1'b1;
    waitIdle();
    devReq = '0;
    check(firstCh == 1 && firstAddr == 16'h7100, "R10 lowest first", firstCh, 1);
    check(xfers == 2 && lastAddr == 16'h7200, "R10 both served", xfers, 2);
    hostRead(A_STAT, d);
  endtask

  task automatic testMasked();
    clearMon();
    hostWrite(A_MASK, 16'h000F);
    devReq[3] = 1'b1;
    repeat (20) @(negedge clk);
    devReq[3] = 1'b0;
    check(holdRises == 0 && xfers == 0, "R9 masked ignored", holdRises + xfers, 0);
  endtask

  task automatic testGrantWait();
    progChan(0, 16'h8000, 16'd0, 16'h0000);
    clearMon();
    stall = 1'b1;
    hostWrite(A_MASK, 16'h000E);
    devReq[0] = 1'b1;
    repeat (10) @(negedge clk);
    check(holdReq == 1'b1 && xfers == 0, "R5 waits for grant", xfers, 0);
    stall = 1'b0;
    waitIdle();
    devReq[0] = 1'b0;
    check(xfers == 1 && holdFalls == 1, "R5 runs after grant", xfers, 1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBlockInc();
    testBlockDecSw();
    testSingle();
    testDemand();
    testEop();
    testAutoInit();
    testPriority();
    testMasked();
    testGrantWait();
    finishRun();
  end
endmodule